// File: doc/BRIEF.md
# Stereo Serial Audio Output Formatter

This block turns parallel left/right sample pairs into a stereo serial audio stream. It drives one data line, and it can also drive a bit clock and a word clock. Samples are two's complement, `SAMPLE_W` bits wide (20 by default), and arrive as one pair per ready/valid transfer. The pair is held in a one-entry pending register. It moves into the active register when the next left channel begins. If nothing new has arrived by then, the active pair is sent again.

All logic runs on a single system clock that runs at 256 or 384 times the output sample rate. In master mode the block divides that clock down to a bit clock at 64 times the sample rate and a word clock at the sample rate. In slave mode it follows a bit clock and word clock supplied from outside, and it holds its own clock outputs low.

The line format is chosen by static configuration inputs:
- a rear-justified normal format, 16, 18 or 20 bits long;
- an IIS-style format with a one-slot delay;
- a pass-through format, fixed at 20 bits and front-justified, which overrides the other two selections.

Top module: `sao_formatter`

## Requirements
- R1: While reset is asserted, `sdata_o` and `bclk_o` are 0 and `in_ready` is 1. `wclk_o` sits at the right-channel level: 0 in normal and pass-through format, 1 in IIS format.
- R2: In master mode, `bclk_o` has a period of 4 system clocks with 2 high when `sys384` is 0. It has a period of 6 system clocks with 3 high when `sys384` is 1.
- R3: Each channel half lasts exactly 32 bit-clock periods. In master mode the word clock changes only together with a falling bit-clock edge. The left channel is sent while the word clock is 1 in normal and pass-through format, and while it is 0 in IIS format. Left comes first, then right.
- R4: Normal format is selected with `iis_fmt`=0 and `thru`=0. It sends the top L bits of the sample, MSB first, with the LSB in slot 31 of the half. Slots 0 to 31-L carry 0. `wlen` 00 gives L=16, 01 gives L=18, and 10 or 11 gives L=20.
- R5: IIS format is selected with `iis_fmt`=1 and `thru`=0. Slot 0 carries 0, the MSB is sent in slot 1, the top L bits fill slots 1 to L, and the remaining slots carry 0.
- R6: When `thru`=1, the top 20 bits of the sample fill slots 0 to 19, MSB first, and slots 20 to 31 carry 0. This happens whatever `wlen` and `iis_fmt` are set to.
- R7: `sdata_o` changes only when the bit clock falls, so it is stable across every rising bit-clock edge.
- R8: `in_ready` is 1 exactly when no pair is pending. A transfer with `in_valid` and `in_ready` both high stores the pair and drops `in_ready` until the pair is consumed at the next left-channel start.
- R9: A left-channel start with no pending pair sends the previous pair again.
- R10: With `slave_mode`=1, frames are timed by `bclk_i`/`wclk_i` under the same slot rules, and `bclk_o` and `wclk_o` stay at 0. Each external bit-clock phase must last at least 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256x or 384x the output sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1: take bit and word clock from outside |
| sys384 | input | 1 | 1: system clock is 384x, 0: 256x (master mode) |
| iis_fmt | input | 1 | 1: IIS framing instead of rear-justified |
| thru | input | 1 | 1: 20-bit front-justified pass-through framing |
| wlen | input | 2 | Word length code (00=16, 01=18, 1x=20) |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pending register is free |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| bclk_i | input | 1 | External bit clock (slave mode) |
| wclk_i | input | 1 | External word clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| wclk_o | output | 1 | Generated word clock (master mode) |
| sdata_o | output | 1 | Serial data |

## Verification
The bench rebuilds every channel half from the data sampled at rising bit-clock edges. It compares each half against a word built from the format rules, which catches any off-by-one in justification. In IIS format that shows up as the MSB landing in slot 0. In normal format it shows up as the LSB falling short of slot 31. In pass-through it shows up as a word length or delay selection leaking through.

The bench measures the bit-clock period and duty for both divider ratios. It also counts data changes seen while the bit clock is high, so a design that updated on the wrong edge is caught.

A second pair is pushed in the middle of a frame. The bench checks that `in_ready` drops, that the new pair appears only at the next left start, and that it then repeats. A design that switched mid-frame or sent stale zeros would fail here.

Slave runs check that the half boundaries follow the external word clock.

// File: rtl/sao_pkg.sv
`timescale 1ns/1ps
package sao_pkg;

   // bit-clock slots per sample period (64fs bit clock) and per channel
   localparam int FRAME_SLOTS = 64;
   localparam int HALF_SLOTS  = FRAME_SLOTS / 2;
   localparam int SLOT_W      = $clog2(FRAME_SLOTS);
   localparam int POS_W       = $clog2(HALF_SLOTS);

   // system-clock ratios and the bit-clock dividers derived from them
   localparam int RATIO_LO    = 256;
   localparam int RATIO_HI    = 384;
   localparam int DIV_LO      = RATIO_LO / FRAME_SLOTS;
   localparam int DIV_HI      = RATIO_HI / FRAME_SLOTS;
   localparam int DIV_W       = $clog2(DIV_HI);

   // longest word on the line; pass-through always uses it
   localparam int MAX_WORD    = 20;

   typedef enum logic [1:0] {
      FR_REAR  = 2'd0,
      FR_IIS   = 2'd1,
      FR_FRONT = 2'd2
   } frame_e;

   // one bit-clock falling event and the slot that starts with it
   typedef struct packed {
      logic              tick;
      logic [SLOT_W-1:0] slot;
   } slot_evt_t;

   function automatic int len_of(input logic [1:0] code);
      case (code)
         2'b00:   return 16;
         2'b01:   return 18;
         default: return 20;
      endcase
   endfunction

endpackage

// File: rtl/sao_master_clk.sv
`timescale 1ns/1ps
module sao_master_clk
   import sao_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sys384,
   output logic      bclk,
   output slot_evt_t evt
);

   if (DIV_LO * FRAME_SLOTS != RATIO_LO || DIV_HI * FRAME_SLOTS != RATIO_HI) begin : g_bad_ratio
      $error("system clock ratios must be multiples of the frame slot count");
   end
   if ((DIV_LO % 2) != 0 || (DIV_HI % 2) != 0) begin : g_bad_duty
      $error("bit-clock dividers must be even for a 50 percent duty");
   end

   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  div_last;
   logic [DIV_W-1:0]  div_rise;
   logic [SLOT_W-1:0] slot_q;
   logic              wrap;

   always_comb begin
      div_last = sys384 ? DIV_W'(DIV_HI - 1)     : DIV_W'(DIV_LO - 1);
      div_rise = sys384 ? DIV_W'(DIV_HI / 2 - 1) : DIV_W'(DIV_LO / 2 - 1);
   end

   assign wrap = (div_q == div_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bclk   <= 1'b0;
         slot_q <= '1;
      end else if (wrap) begin
         div_q  <= '0;
         bclk   <= 1'b0;
         slot_q <= slot_q + SLOT_W'(1);
      end else begin
         div_q <= div_q + DIV_W'(1);
         if (div_q == div_rise) begin
            bclk <= 1'b1;
         end
      end
   end

   assign evt.tick = wrap;
   assign evt.slot = slot_q + SLOT_W'(1);

endmodule

// File: rtl/sao_slave_track.sv
`timescale 1ns/1ps
module sao_slave_track
   import sao_pkg::*;
#(
   parameter int SYNC_STAGES = 2
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bclk_ext,
   input  logic      wclk_ext,
   input  logic      left_high,
   output slot_evt_t evt
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] b_sync;
   logic [SYNC_STAGES-1:0] w_sync;
   logic                   b_prev;
   logic                   w_last;
   logic [POS_W-1:0]       pos_q;
   logic [POS_W-1:0]       pos_nxt;
   logic                   b_s;
   logic                   w_s;
   logic                   fall;
   logic                   is_left;

   assign b_s     = b_sync[SYNC_STAGES-1];
   assign w_s     = w_sync[SYNC_STAGES-1];
   assign fall    = b_prev & ~b_s;
   assign is_left = left_high ? w_s : ~w_s;

   always_comb begin
      if (w_s != w_last) begin
         pos_nxt = '0;
      end else if (pos_q == POS_W'(HALF_SLOTS - 1)) begin
         pos_nxt = pos_q;
      end else begin
         pos_nxt = pos_q + POS_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_sync <= '0;
         w_sync <= '0;
         b_prev <= 1'b0;
         w_last <= 1'b0;
         pos_q  <= '1;
      end else begin
         b_sync <= {b_sync[SYNC_STAGES-2:0], bclk_ext};
         w_sync <= {w_sync[SYNC_STAGES-2:0], wclk_ext};
         b_prev <= b_s;
         if (fall) begin
            w_last <= w_s;
            pos_q  <= pos_nxt;
         end
      end
   end

   assign evt.tick = fall;
   assign evt.slot = {~is_left, pos_nxt};

endmodule

// File: rtl/sao_sample_hold.sv
`timescale 1ns/1ps
module sao_sample_hold #(
   parameter int SAMPLE_W = 20
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic                frame_start,
   output logic [SAMPLE_W-1:0] src_left,
   output logic [SAMPLE_W-1:0] src_right
);

   logic                pend_v;
   logic [SAMPLE_W-1:0] pend_l, pend_r;
   logic [SAMPLE_W-1:0] cur_l, cur_r;
   logic                take;

   assign in_ready  = ~pend_v;
   assign take      = frame_start & pend_v;
   assign src_left  = take ? pend_l : cur_l;
   assign src_right = take ? pend_r : cur_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_l <= '0;
         pend_r <= '0;
         cur_l  <= '0;
         cur_r  <= '0;
      end else if (take) begin
         cur_l  <= pend_l;
         cur_r  <= pend_r;
         pend_v <= 1'b0;
      end else if (in_valid && !pend_v) begin
         pend_l <= in_left;
         pend_r <= in_right;
         pend_v <= 1'b1;
      end
   end

endmodule

// File: rtl/sao_serializer.sv
`timescale 1ns/1ps
module sao_serializer
   import sao_pkg::*;
#(
   parameter int SAMPLE_W = 20
)(
   input  logic                clk,
   input  logic                rst_n,
   input  slot_evt_t           evt,
   input  logic                left_high,
   input  logic                iis_fmt,
   input  logic                thru,
   input  logic [1:0]          wlen,
   input  logic [SAMPLE_W-1:0] src_left,
   input  logic [SAMPLE_W-1:0] src_right,
   output logic                sdata,
   output logic                wclk
);

   frame_e              mode;
   logic [SAMPLE_W-1:0] word;
   logic [SAMPLE_W-1:0] shifted;
   logic                half;
   logic                hit;
   logic                bit_v;
   int                  pos;
   int                  len;
   int                  idx;

   assign half = evt.slot[SLOT_W-1];

   always_comb begin
      if (thru)         mode = FR_FRONT;
      else if (iis_fmt) mode = FR_IIS;
      else              mode = FR_REAR;
   end

   always_comb begin
      word    = half ? src_right : src_left;
      pos     = int'(evt.slot[POS_W-1:0]);
      len     = len_of(wlen);
      hit     = 1'b0;
      idx     = 0;
      shifted = '0;
      case (mode)
         FR_FRONT: begin
            hit = (pos < MAX_WORD);
            idx = SAMPLE_W - 1 - pos;
         end
         FR_IIS: begin
            hit = (pos >= 1) && (pos <= len);
            idx = SAMPLE_W - pos;
         end
         default: begin
            hit = (pos >= HALF_SLOTS - len);
            idx = SAMPLE_W - 1 - pos + HALF_SLOTS - len;
         end
      endcase
      if (hit) begin
         shifted = word >> idx;
      end
      bit_v = hit & shifted[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdata <= 1'b0;
         wclk  <= ~left_high;
      end else if (evt.tick) begin
         sdata <= bit_v;
         wclk  <= left_high ? ~half : half;
      end
   end

endmodule

// File: rtl/sao_formatter.sv
`timescale 1ns/1ps
module sao_formatter
   import sao_pkg::*;
#(
   parameter int SAMPLE_W    = 20,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_SLAVE   = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                slave_mode,
   input  logic                sys384,
   input  logic                iis_fmt,
   input  logic                thru,
   input  logic [1:0]          wlen,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic                bclk_i,
   input  logic                wclk_i,
   output logic                bclk_o,
   output logic                wclk_o,
   output logic                sdata_o
);

   if (SAMPLE_W < MAX_WORD || SAMPLE_W > HALF_SLOTS) begin : g_bad_width
      $error("SAMPLE_W must lie between the longest word and the slot count");
   end

   slot_evt_t           m_evt;
   slot_evt_t           s_evt;
   slot_evt_t           evt;
   logic                m_bclk;
   logic                ser_wclk;
   logic                left_high;
   logic                use_slave;
   logic                frame_start;
   logic [SAMPLE_W-1:0] src_l, src_r;

   assign left_high = thru | ~iis_fmt;

   sao_master_clk u_mclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .sys384 (sys384),
      .bclk   (m_bclk),
      .evt    (m_evt)
   );

   if (HAS_SLAVE) begin : g_slave
      sao_slave_track #(.SYNC_STAGES(SYNC_STAGES)) u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .bclk_ext  (bclk_i),
         .wclk_ext  (wclk_i),
         .left_high (left_high),
         .evt       (s_evt)
      );
      assign use_slave = slave_mode;
   end else begin : g_master_only
      assign s_evt     = '0;
      assign use_slave = 1'b0;
   end

   assign evt         = use_slave ? s_evt : m_evt;
   assign frame_start = evt.tick && (evt.slot == '0);

   sao_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_left     (in_left),
      .in_right    (in_right),
      .frame_start (frame_start),
      .src_left    (src_l),
      .src_right   (src_r)
   );

   sao_serializer #(.SAMPLE_W(SAMPLE_W)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .left_high (left_high),
      .iis_fmt   (iis_fmt),
      .thru      (thru),
      .wlen      (wlen),
      .src_left  (src_l),
      .src_right (src_r),
      .sdata     (sdata_o),
      .wclk      (ser_wclk)
   );

   assign bclk_o = use_slave ? 1'b0 : m_bclk;
   assign wclk_o = use_slave ? 1'b0 : ser_wclk;

endmodule

// File: rtl/sao_formatter_chk.sv
`timescale 1ns/1ps
module sao_formatter_chk (
   input logic clk,
   input logic rst_n,
   input logic slave_mode,
   input logic in_valid,
   input logic in_ready,
   input logic bclk_o,
   input logic wclk_o,
   input logic sdata_o
);

   // R7
   sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && bclk_o && $past(bclk_o)) |-> $stable(sdata_o));

   // R8
   accept_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R2
   bclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && $rose(bclk_o)) |=> bclk_o);

   // R2
   bclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && $fell(bclk_o)) |=> !bclk_o);

   // R3
   wclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && (wclk_o != $past(wclk_o))) |-> $fell(bclk_o));

endmodule

bind sao_formatter sao_formatter_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slave_mode (slave_mode),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .bclk_o     (bclk_o),
   .wclk_o     (wclk_o),
   .sdata_o    (sdata_o)
);

// File: tb/sao_formatter_test.sv
`timescale 1ns/1ps
module sao_formatter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slave_mode = 1'b0, sys384 = 1'b0, iis_fmt = 1'b0, thru = 1'b0;
   logic [1:0]  wlen = 2'b00;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [19:0] in_left = '0, in_right = '0;
   logic        bclk_i = 1'b0, wclk_i = 1'b0;
   logic        bclk_o, wclk_o, sdata_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sao_formatter uut (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .sys384(sys384),
      .iis_fmt(iis_fmt), .thru(thru), .wlen(wlen), .in_valid(in_valid),
      .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
      .bclk_i(bclk_i), .wclk_i(wclk_i), .bclk_o(bclk_o), .wclk_o(wclk_o),
      .sdata_o(sdata_o)
   );

   // level of the word clock during the left channel
   bit left_pol;
   assign left_pol = thru | ~iis_fmt;

   // ---------------- external clock source for slave runs ----------------
   bit slv_run = 1'b0;
   int s_sub = 11, s_slot = 63;
   initial begin
      forever begin
         @(posedge clk); #1;
         if (!slv_run) begin
            s_sub = 11; s_slot = 63; bclk_i = 1'b0; wclk_i = ~left_pol;
         end else begin
            s_sub = (s_sub + 1) % 12;
            if (s_sub == 0) begin
               bclk_i = 1'b0;
               s_slot = (s_slot + 1) % 64;
               wclk_i = (s_slot < 32) ? left_pol : ~left_pol;
            end else if (s_sub == 6) begin
               bclk_i = 1'b1;
            end
         end
      end
   end

   // ---------------- line monitor ----------------
   bit          m_bprev, m_wlast, m_started, m_curleft, m_have_l, m_sprev;
   int          m_pos, frame_cnt, half_bad, glitch;
   logic [31:0] m_sh, m_lw, fr_l, fr_r;
   always @(negedge clk) begin
      logic bo, wo;
      bo = slave_mode ? bclk_i : bclk_o;
      wo = slave_mode ? wclk_i : wclk_o;
      if (!rst_n) begin
         m_bprev = 1'b0; m_wlast = ~left_pol; m_started = 1'b0; m_have_l = 1'b0;
         m_pos = 0; frame_cnt = 0; half_bad = 0; glitch = 0; m_sh = '0;
      end else begin
         if (bo && m_bprev && (sdata_o != m_sprev)) glitch++;
         if (bo && !m_bprev) begin
            if (wo != m_wlast) begin
               if (m_started && m_pos != 32) half_bad++;
               m_started = 1'b1; m_wlast = wo; m_curleft = (wo == left_pol);
               m_pos = 1; m_sh = {31'b0, sdata_o};
            end else begin
               m_pos++; m_sh = {m_sh[30:0], sdata_o};
            end
            if (m_started && m_pos == 32) begin
               if (m_curleft) begin
                  m_lw = m_sh; m_have_l = 1'b1;
               end else if (m_have_l) begin
                  fr_l = m_lw; fr_r = m_sh; m_have_l = 1'b0; frame_cnt++;
               end
            end
         end
         m_bprev = bo;
      end
      m_sprev = sdata_o;
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_half(input logic [19:0] w, input logic [1:0] code,
                                            input bit iis, input bit th);
      int L;
      logic [31:0] top;
      L = (code == 2'b00) ? 16 : (code == 2'b01) ? 18 : 20;
      top = 32'(w) >> (20 - L);
      if (th) return 32'(w) << 12;
      if (iis) return top << (31 - L);
      return top;
   endfunction

   task automatic do_reset(input bit slv, input bit s384, input bit iis, input bit th,
                           input logic [1:0] wl);
      rst_n = 1'b0; slv_run = 1'b0;
      slave_mode = slv; sys384 = s384; iis_fmt = iis; thru = th; wlen = wl;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1; slv_run = slv;
   endtask

   task automatic push(input logic [19:0] l, input logic [19:0] r);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_left = l; in_right = r;
      @(posedge clk); #1 in_valid = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      int target;
      target = frame_cnt + n;
      while (frame_cnt < target) @(negedge clk);
   endtask

   task automatic check_frame(input string req, input logic [19:0] l, input logic [19:0] r);
      check(fr_l == exp_half(l, wlen, iis_fmt, thru), req, "left half", fr_l,
            exp_half(l, wlen, iis_fmt, thru));
      check(fr_r == exp_half(r, wlen, iis_fmt, thru), req, "right half", fr_r,
            exp_half(r, wlen, iis_fmt, thru));
      check(half_bad == 0, "R3", "half length not 32 slots", 32'(half_bad), 0);
      check(glitch == 0, "R7", "data moved while bit clock high", 32'(glitch), 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      do_reset(1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
      rst_n = 1'b0;
      @(negedge clk);
      check(sdata_o == 1'b0, "R1", "sdata in reset", 32'(sdata_o), 0);
      check(bclk_o == 1'b0, "R1", "bclk in reset", 32'(bclk_o), 0);
      check(wclk_o == 1'b0, "R1", "wclk normal in reset", 32'(wclk_o), 0);
      check(in_ready == 1'b1, "R1", "ready in reset", 32'(in_ready), 1);
      iis_fmt = 1'b1;
      @(negedge clk);
      check(wclk_o == 1'b1, "R1", "wclk iis in reset", 32'(wclk_o), 1);
   endtask

   task automatic t_master_clock(input bit s384);
      int cyc, r1, r2, hi, div;
      bit pv;
      do_reset(1'b0, s384, 1'b0, 1'b0, 2'b10);
      div = s384 ? 6 : 4;
      cyc = 0; r1 = -1; r2 = -1; hi = 0; pv = 1'b0;
      repeat (60) begin
         @(negedge clk); cyc++;
         if (bclk_o && !pv) begin
            if (r1 < 0) r1 = cyc; else if (r2 < 0) r2 = cyc;
         end
         if (r1 >= 0 && r2 < 0 && bclk_o) hi++;
         pv = bclk_o;
      end
      check(r2 - r1 == div, "R2", "bit clock period", 32'(r2 - r1), 32'(div));
      check(hi == div / 2, "R2", "bit clock high time", 32'(hi), 32'(div / 2));
   endtask

   task automatic t_format(input string req, input bit slv, input bit s384, input bit iis,
                           input bit th, input logic [1:0] wl,
                           input logic [19:0] l, input logic [19:0] r);
      do_reset(slv, s384, iis, th, wl);
      push(l, r);
      wait_frames(2);
      check_frame(req, l, r);
   endtask

   task automatic t_handshake();
      do_reset(1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
      push(20'h13579, 20'hECA86);
      wait_frames(2);
      check_frame("R9", 20'h13579, 20'hECA86);
      check(in_ready == 1'b1, "R8", "ready after consume", 32'(in_ready), 1);
      push(20'h8000F, 20'h7FFF0);
      @(negedge clk);
      check(in_ready == 1'b0, "R8", "ready while pending", 32'(in_ready), 0);
      wait_frames(2);
      check_frame("R8", 20'h8000F, 20'h7FFF0);
      check(in_ready == 1'b1, "R8", "ready after next left start", 32'(in_ready), 1);
      wait_frames(1);
      check_frame("R9", 20'h8000F, 20'h7FFF0);
   endtask

   task automatic t_slave();
      t_format("R10", 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 20'hC3A5B, 20'h2D0F1);
      check(bclk_o == 1'b0 && wclk_o == 1'b0, "R10", "clock outputs held low",
            {30'b0, bclk_o, wclk_o}, 0);
      t_format("R10", 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 20'h9E371, 20'h4B2C8);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_master_clock(1'b0);
      t_master_clock(1'b1);
      t_format("R4", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 20'hA5C3F, 20'h1234E);
      t_format("R4", 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 20'hA5C3F, 20'h1234E);
      t_format("R4", 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 20'hF0F0F, 20'h0F0F1);
      t_format("R5", 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 20'hB6D9F, 20'h80001);
      t_format("R5", 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 20'hB6D9F, 20'h80001);
      t_format("R6", 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 20'hDEADB, 20'h3C5A7);
      t_handshake();
      t_slave();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule